// File: doc/BRIEF.md
# Two-Level Multicart Program Bank Mapper

This block is the banking logic on a cartridge for an 8-bit console. It watches CPU write cycles and holds two small registers. The outer register chooses a 128 KiB block of program ROM and the nametable mirroring. The inner page register chooses a 16 KiB page inside that block.

The CPU sees program ROM through two 16 KiB windows. The lower window, at `$8000-$BFFF`, shows the inner page of the current block. The upper window, at `$C000-$FFFF`, always shows the last page of the current block. The block drives the upper program-ROM address lines, the ROM chip enable, the nametable-RAM A10 select and the enable for the single fixed 8 KiB character RAM.

The CPU interface is a plain bus with a strobe. The console bus cannot be stalled, so the block has no valid/ready handshake and applies no back-pressure. Every write that qualifies is taken in the clock cycle in which it is sampled.

Top module: `mcart_prg_mapper`

## Requirements
- R1: A qualified write hits the outer register when `(cpu_addr & 16'hC100) == 16'h4100`; all other address bits are don't-care (for example `$41FE` hits).
- R2: Outer data bits 3:0 set the block number, which drives `prg_addr[20:17]` in both windows. Data bit 4 sets the mirroring (0 vertical, 1 horizontal). Data bits 7:5 are ignored.
- R3: A qualified write with `cpu_addr[15]=1` loads the inner register from bits 2:0 of the effective data; bits 7:3 are ignored.
- R4: The effective inner data is `cpu_wdata & rom_rdata`, where `rom_rdata` is the ROM byte at the address being written (bus conflict). Outer writes are not ANDed.
- R5: `prg_addr = {page, cpu_addr[13:0]}`. When `cpu_addr[14]=0`, page = `{outer, inner}`.
- R6: When `cpu_addr[14]=1`, page = `{outer, 3'b111}`. Inner writes never change it.
- R7: After reset, outer, inner and mirroring are all zero, so `$8000` maps to page 0, `$C000` maps to page 7, and mirroring is vertical.
- R8: `ciram_a10` equals `ppu_a10` under vertical mirroring and `ppu_a11` under horizontal mirroring.
- R9: `prg_ce` is high only when `cpu_rw=1` and `cpu_addr[15]=1`.
- R10: A write is qualified only when `cpu_m2=1` and `cpu_rw=0` at a rising clock edge. Unqualified cycles, and writes to addresses that match neither register, leave all mapping outputs unchanged.
- R11: `chr_ram_ce` is high exactly when `ppu_a13=0`. The character RAM is not banked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; qualified writes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | Bus phase strobe; qualifies writes |
| rom_rdata | input | 8 | Byte the program ROM drives at the current address |
| ppu_a10 | input | 1 | Video address bit 10 |
| ppu_a11 | input | 1 | Video address bit 11 |
| ppu_a13 | input | 1 | Video address bit 13 |
| prg_addr | output | 21 | Program ROM address (page and offset) |
| prg_ce | output | 1 | Program ROM chip enable |
| ciram_a10 | output | 1 | Nametable RAM A10 select |
| chr_ram_ce | output | 1 | Character RAM enable |

## Verification
The assertions are checked on every cycle. They cover these rules:
- the register loads and the reset values (R1, R2, R3, R4, R7);
- registers hold on cycles with no qualified write, or a write that misses (R10);
- the upper window stays pinned (R6);
- the lower window follows the ANDed data after an inner write (R4, R5);
- no chip enable during writes (R9);
- the mirror select and the character-RAM enable (R8, R11).

Only the bench scenarios can show the following:
- the address decode with don't-care bits;
- that the upper data bits are dropped;
- that the mapping is right across many sequences of outer and inner writes, with a ROM model that stores each page's own index;
- that nothing changes after stray or unqualified writes.

// File: rtl/mcart_pkg.sv
package mcart_pkg;
  localparam int unsigned CPU_AW = 16;
  localparam int unsigned CPU_DW = 8;

  typedef enum logic {
    MIR_VERT = 1'b0,
    MIR_HORZ = 1'b1
  } mirror_e;
endpackage

// File: rtl/mcart_outer_reg.sv
module mcart_outer_reg
  import mcart_pkg::*;
#(
  parameter int unsigned OUTER_W   = 4,
  parameter logic [15:0] DEC_MASK  = 16'hC100,
  parameter logic [15:0] DEC_MATCH = 16'h4100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [CPU_AW-1:0]  addr,
  input  logic [OUTER_W:0]   wdata,
  output logic [OUTER_W-1:0] outer_q,
  output mirror_e            mir_q
);
  logic hit;
  assign hit = ((addr & DEC_MASK) == DEC_MATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      outer_q <= '0;
      mir_q   <= MIR_VERT;
    end else if (wr_stb && hit) begin
      outer_q <= wdata[OUTER_W-1:0];
      mir_q   <= mirror_e'(wdata[OUTER_W]);
    end
  end

  AST_OUTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && hit) |=> (outer_q == $past(wdata[OUTER_W-1:0])
                         && mir_q == mirror_e'($past(wdata[OUTER_W])))); // R2
  AST_OUTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && hit) |=> ($stable(outer_q) && $stable(mir_q))); // R10
  AST_OUTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (outer_q == '0 && mir_q == MIR_VERT)); // R7
endmodule

// File: rtl/mcart_inner_reg.sv
module mcart_inner_reg
  import mcart_pkg::*;
#(
  parameter int unsigned INNER_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic               rom_space,
  input  logic [INNER_W-1:0] wdata,
  input  logic [INNER_W-1:0] rom_rdata,
  output logic [INNER_W-1:0] inner_q
);
  // Open-collector style contention: both drivers pull the line low
  logic [INNER_W-1:0] eff;
  assign eff = wdata & rom_rdata;

  always_ff @(posedge clk) begin
    if (rst)                        inner_q <= '0;
    else if (wr_stb && rom_space)   inner_q <= eff;
  end

  AST_INNER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && rom_space) |=> $stable(inner_q)); // R10
  AST_INNER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (inner_q == '0)); // R7
endmodule

// File: rtl/mcart_window_map.sv
module mcart_window_map
  import mcart_pkg::*;
#(
  parameter int unsigned OUTER_W = 4,
  parameter int unsigned INNER_W = 3,
  parameter int unsigned OFS_W   = 14,
  localparam int unsigned PAGE_W = OUTER_W + INNER_W,
  localparam int unsigned PRG_AW = PAGE_W + OFS_W
) (
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_rw,
  input  logic [OUTER_W-1:0] outer_q,
  input  logic [INNER_W-1:0] inner_q,
  input  mirror_e            mir_q,
  input  logic               ppu_a10,
  input  logic               ppu_a11,
  input  logic               ppu_a13,
  output logic [PRG_AW-1:0]  prg_addr,
  output logic               prg_ce,
  output logic               ciram_a10,
  output logic               chr_ram_ce
);
  logic [INNER_W-1:0] low_sel;
  logic [PAGE_W-1:0]  page;

  // Upper window is forced to the last page of the block
  always_comb begin
    if (cpu_addr[OFS_W]) low_sel = '1;
    else                 low_sel = inner_q;
  end

  assign page       = {outer_q, low_sel};
  assign prg_addr   = {page, cpu_addr[OFS_W-1:0]};
  assign prg_ce     = cpu_rw & cpu_addr[CPU_AW-1];
  assign ciram_a10  = (mir_q == MIR_HORZ) ? ppu_a11 : ppu_a10;
  assign chr_ram_ce = ~ppu_a13;
endmodule

// File: rtl/mcart_prg_mapper.sv
module mcart_prg_mapper
  import mcart_pkg::*;
#(
  parameter int unsigned OUTER_W   = 4,
  parameter int unsigned INNER_W   = 3,
  parameter int unsigned OFS_W     = 14,
  parameter logic [15:0] DEC_MASK  = 16'hC100,
  parameter logic [15:0] DEC_MATCH = 16'h4100,
  localparam int unsigned PAGE_W   = OUTER_W + INNER_W,
  localparam int unsigned PRG_AW   = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_wdata,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  input  logic [CPU_DW-1:0] rom_rdata,
  input  logic              ppu_a10,
  input  logic              ppu_a11,
  input  logic              ppu_a13,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_ce,
  output logic              ciram_a10,
  output logic              chr_ram_ce
);
  logic               wr_stb;
  logic [OUTER_W-1:0] outer_q;
  logic [INNER_W-1:0] inner_q;
  mirror_e            mir_q;

  assign wr_stb = cpu_m2 & ~cpu_rw;

  mcart_outer_reg #(
    .OUTER_W(OUTER_W), .DEC_MASK(DEC_MASK), .DEC_MATCH(DEC_MATCH)
  ) outer_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(cpu_addr),
    .wdata(cpu_wdata[OUTER_W:0]), .outer_q(outer_q), .mir_q(mir_q)
  );

  mcart_inner_reg #(.INNER_W(INNER_W)) inner_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rom_space(cpu_addr[CPU_AW-1]),
    .wdata(cpu_wdata[INNER_W-1:0]), .rom_rdata(rom_rdata[INNER_W-1:0]),
    .inner_q(inner_q)
  );

  mcart_window_map #(
    .OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFS_W(OFS_W)
  ) map_i (
    .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .outer_q(outer_q),
    .inner_q(inner_q), .mir_q(mir_q), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
    .ppu_a13(ppu_a13), .prg_addr(prg_addr), .prg_ce(prg_ce),
    .ciram_a10(ciram_a10), .chr_ram_ce(chr_ram_ce)
  );

  AST_UPPER_PINNED: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[OFS_W] == 1'b1) |->
      (prg_addr[PRG_AW-1:OFS_W] == {outer_q, {INNER_W{1'b1}}})); // R6
  AST_INNER_NO_OUTER: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && cpu_addr[CPU_AW-1]) |=> $stable(outer_q)); // R6
  AST_LOWER_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && cpu_addr[CPU_AW-1]) |=>
      (cpu_addr[OFS_W] || prg_addr[OFS_W+INNER_W-1:OFS_W] ==
        ($past(cpu_wdata[INNER_W-1:0]) & $past(rom_rdata[INNER_W-1:0])))); // R4
  AST_NO_CE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !cpu_rw |-> !prg_ce); // R9
  AST_MIRROR_SEL: assert property (@(posedge clk) disable iff (rst)
    (ppu_a10 == ppu_a11) |-> (ciram_a10 == ppu_a10)); // R8
  AST_CHR_EN: assert property (@(posedge clk) disable iff (rst)
    ppu_a13 |-> !chr_ram_ce); // R11
endmodule

// File: tb/mcart_prg_mapper_tb_top.sv
module mcart_prg_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rw, cpu_m2;
  logic [7:0]  rom_rdata;
  logic        ppu_a10, ppu_a11, ppu_a13;
  logic [20:0] prg_addr;
  logic        prg_ce, ciram_a10, chr_ram_ce;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [3:0] m_outer;
  logic [2:0] m_inner;
  logic       m_horz;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ROM model: low half of every page holds the page index, high half 0xFF
  function automatic logic [7:0] rom_of(logic [20:0] a);
    return a[13] ? 8'hFF : {1'b0, a[20:14]};
  endfunction
  assign rom_rdata = rom_of(prg_addr);

  mcart_prg_mapper dut_i (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .rom_rdata(rom_rdata),
    .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .ppu_a13(ppu_a13),
    .prg_addr(prg_addr), .prg_ce(prg_ce), .ciram_a10(ciram_a10),
    .chr_ram_ce(chr_ram_ce)
  );

  function automatic logic [6:0] exp_page(logic upper);
    return {m_outer, upper ? 3'b111 : m_inner};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus(logic [15:0] a, logic [7:0] d, logic rw, logic m2);
    logic [7:0] rb;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rw = rw; cpu_m2 = m2;
    rb = a[13] ? 8'hFF : {1'b0, exp_page(a[14])};
    @(negedge clk);
    cpu_rw = 1'b1; cpu_m2 = 1'b0; cpu_addr = 16'h0000;
    if (m2 && !rw) begin
      if ((a & 16'hC100) == 16'h4100) begin
        m_outer = d[3:0]; m_horz = d[4];
      end else if (a[15]) begin
        m_inner = d[2:0] & rb[2:0];
      end
    end
  endtask

  task automatic check_windows(string req);
    logic [13:0] ofs;
    for (int w = 0; w < 2; w++) begin
      ofs = 14'($urandom);
      cpu_rw = 1'b1; cpu_m2 = 1'b1;
      cpu_addr = {1'b1, w[0], ofs};
      #1;
      chk(prg_addr == {exp_page(w[0]), ofs}, w ? {req, "/R6 upper"} : {req, "/R5 lower"},
          int'(prg_addr), int'({exp_page(w[0]), ofs}));
      chk(prg_ce == 1'b1, "R9 ce on read", int'(prg_ce), 1);
    end
    for (int p = 0; p < 8; p++) begin
      {ppu_a13, ppu_a11, ppu_a10} = 3'(p);
      #1;
      chk(ciram_a10 == (m_horz ? ppu_a11 : ppu_a10), "R8 mirror",
          int'(ciram_a10), int'(m_horz ? ppu_a11 : ppu_a10));
      chk(chr_ram_ce == !ppu_a13, "R11 chr enable", int'(chr_ram_ce), int'(!ppu_a13));
    end
    cpu_rw = 1'b0; cpu_m2 = 1'b0; cpu_addr = 16'h8000;
    #1;
    chk(prg_ce == 1'b0, "R9 no ce on write", int'(prg_ce), 0);
    cpu_rw = 1'b1; cpu_addr = 16'h7FFF;
    #1;
    chk(prg_ce == 1'b0, "R9 no ce below rom", int'(prg_ce), 0);
    cpu_m2 = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_outer = '0; m_inner = '0; m_horz = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    logic [15:0] a;
    int kind;
    void'($urandom(32'd20240611));
    cpu_addr = '0; cpu_wdata = '0; cpu_rw = 1'b1; cpu_m2 = 1'b0;
    ppu_a10 = 0; ppu_a11 = 0; ppu_a13 = 0;
    do_reset();
    check_windows("R7 reset");

    // Directed corners
    bus(16'h41FE, 8'h02, 1'b0, 1'b1); check_windows("R1 masked decode");
    bus(16'h4100, 8'hFF, 1'b0, 1'b1); check_windows("R2 upper bits dropped");
    chk(m_outer == 4'hF && m_horz, "R2 model", int'(m_outer), 15);
    bus(16'hA000, 8'hFD, 1'b0, 1'b1); check_windows("R3 high bits ignored");
    bus(16'h4100, 8'h00, 1'b0, 1'b1);
    bus(16'hA123, 8'h06, 1'b0, 1'b1);          // inner 6, page 6
    bus(16'h8003, 8'h03, 1'b0, 1'b1);          // 3 & 6 -> 2
    check_windows("R4 conflict");
    chk(m_inner == 3'd2, "R4 model", int'(m_inner), 2);
    bus(16'hC000, 8'h05, 1'b0, 1'b1); check_windows("R6 write via upper");
    bus(16'h8000, 8'h07, 1'b0, 1'b0); check_windows("R10 m2 low");
    bus(16'h4100, 8'h1F, 1'b1, 1'b1); check_windows("R10 read at outer");
    bus(16'h4000, 8'h1F, 1'b0, 1'b1); check_windows("R10 miss bit8");
    bus(16'h0100 | 16'h4000 | 16'h8000, 8'h1F, 1'b0, 1'b1); check_windows("R1 C100 hits inner");
    bus(16'h4100, 8'h13, 1'b0, 1'b1);
    do_reset();
    check_windows("R7 reset after use");

    for (int i = 0; i < 400; i++) begin
      a = 16'($urandom);
      kind = int'($urandom_range(0, 4));
      case (kind)
        0: begin a[15:14] = 2'b01; a[8] = 1'b1; bus(a, 8'($urandom), 1'b0, 1'b1); end
        1, 2: begin a[15] = 1'b1; bus(a, 8'($urandom), 1'b0, 1'b1); end
        3: begin a[15] = 1'b0; a[8] = 1'b0; bus(a, 8'($urandom), 1'b0, 1'b1); end
        default: bus(a, 8'($urandom), 1'($urandom), 1'b0);
      endcase
      check_windows("R5/R1/R3 random");
    end

    done = 1;
    finish_run();
  end
endmodule